// File: doc/BRIEF.md
# Instruction Address Watchpoint Unit

The unit watches the stream of retiring instruction addresses. It holds four programmable comparators, numbered 0 to 3, and checks every retiring address against their reference words. Each comparator works on the word address, which is the address with its two lowest bits dropped, so it compares 30 bits. Each comparator produces two raw results: equal and less-than. A per-comparator type select turns these two results into one event:

- equal
- not equal
- greater than, meaning neither equal nor less
- less than

Inclusive bounds are built by the programmer from strict bounds that are one word further out.

The comparators are grouped into fixed pairs, (0,1) and (2,3). Each pair has a combine mode:

- **Independent:** each comparator drives its own watchpoint.
- **AND:** in-range detection.
- **OR:** out-of-range detection.

Any asserted watchpoint can be enabled to raise a registered breakpoint request.

The address input is a valid/ready stream. The unit never applies back-pressure: `in_ready` is held high, and an address is consumed in every cycle where `in_valid` is high. The configuration pins are plain static levels. Software changes them only while no instruction is retiring.

Top module: `iaddr_watch`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset. The results for an address accepted at one clock edge appear on `wp_hit` and `brk_req` after that edge and hold until the next edge.
- R2: The comparisons use only address bits [31:2]. Bits [1:0] of `in_addr` have no effect on any result.
- R3: The comparisons are unsigned. For example, 0xFFFF_FFF0 is greater than 0x0000_0010.
- R4: The 2-bit type field of comparator k is `cfg_type[2k+1:2k]`. Its codes are 00 equal, 01 not equal, 10 greater than, and 11 less than. A code defines the relation of the incoming address to the reference.
- R5: A comparator whose `cfg_en` bit is 0 produces no event.
- R6: Pair p uses comparators 2p and 2p+1. Its mode is `cfg_pair_mode[2p+1:2p]`. Mode 00 (independent) drives `wp_hit[2p]` from comparator 2p and `wp_hit[2p+1]` from comparator 2p+1.
- R7: Mode 01 (AND) sets `wp_hit[2p]` only when both events of the pair hold, and it keeps `wp_hit[2p+1]` at 0.
- R8: Mode 10 (OR) sets `wp_hit[2p]` when either event of the pair holds, and it keeps `wp_hit[2p+1]` at 0. Mode 11 behaves like mode 00.
- R9: `brk_req` is high in the same cycle as `wp_hit`, exactly when some watchpoint is high and its `cfg_brk_en` bit is set.
- R10: In a cycle that follows an edge with `in_valid` low, `wp_hit` and `brk_req` are 0. Each qualifying address therefore gives a pulse of one cycle.
- R11: While `rst_n` is low, and right after reset is released, `wp_hit` and `brk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A retiring instruction address is present |
| in_ready | output | 1 | The unit accepts the address (always 1) |
| in_addr | input | 32 | Retiring instruction byte address |
| cfg_ref | input | 120 | Four 30-bit reference word addresses; comparator k uses bits [30k+29:30k] |
| cfg_type | input | 8 | 2-bit compare type for each comparator |
| cfg_en | input | 4 | Enable for each comparator |
| cfg_pair_mode | input | 4 | 2-bit combine mode for each pair |
| cfg_brk_en | input | 4 | Breakpoint enable for each watchpoint |
| wp_hit | output | 4 | Watchpoint pulses, registered |
| brk_req | output | 1 | Instruction breakpoint request, registered |

## Verification
All results come from a single register stage, so they are due one clock edge after the address is accepted. The bench drives `in_valid` and `in_addr` on a falling edge. The rising edge that follows captures the address. The bench samples `wp_hit` and `brk_req` at the next falling edge, which is exactly one cycle later. It then drops `in_valid` and samples again one cycle after that, which confirms that the pulse ends (R10). Configuration changes only while `in_valid` is low, so every check sees a stable set of references and modes.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
  typedef enum logic [1:0] {
    CT_EQ = 2'b00,
    CT_NE = 2'b01,
    CT_GT = 2'b10,
    CT_LT = 2'b11
  } cmp_type_e;

  typedef enum logic [1:0] {
    PM_SOLO  = 2'b00,
    PM_AND   = 2'b01,
    PM_OR    = 2'b10,
    PM_SOLO2 = 2'b11
  } pair_mode_e;
endpackage

// File: rtl/iaw_comparator.sv
module iaw_comparator #(
  parameter int W = 30
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] ref_val,
  output logic         is_eq,
  output logic         is_lt
);
  // Unsigned magnitude compare (R3)
  always_comb begin
    is_eq = (key == ref_val);
    is_lt = (key < ref_val);
  end

  always_comb begin
    assert (!(is_eq && is_lt)) else $error("p_eq_lt_excl_r3");
  end
endmodule

// File: rtl/iaw_event_map.sv
module iaw_event_map
  import iaw_pkg::*;
(
  input  logic      is_eq,
  input  logic      is_lt,
  input  cmp_type_e ctype,
  input  logic      enable,
  output logic      event_o
);
  logic raw;

  // R4: every relation comes from the two raw results
  always_comb begin
    unique case (ctype)
      CT_EQ:   raw = is_eq;
      CT_NE:   raw = !is_eq;
      CT_GT:   raw = !is_eq && !is_lt;
      CT_LT:   raw = is_lt;
      default: raw = 1'b0;
    endcase
    event_o = enable && raw; // R5
  end
endmodule

// File: rtl/iaw_pair_combine.sv
module iaw_pair_combine
  import iaw_pkg::*;
(
  input  logic       ev_lo,
  input  logic       ev_hi,
  input  pair_mode_e mode,
  output logic       wp_lo,
  output logic       wp_hi
);
  always_comb begin
    unique case (mode)
      PM_AND: begin wp_lo = ev_lo && ev_hi; wp_hi = 1'b0; end   // R7
      PM_OR:  begin wp_lo = ev_lo || ev_hi; wp_hi = 1'b0; end   // R8
      default: begin wp_lo = ev_lo; wp_hi = ev_hi; end          // R6, R8
    endcase
  end

  always_comb begin
    if (mode == PM_AND && wp_lo)
      assert (ev_lo && ev_hi) else $error("p_and_needs_both_r7");
    if (mode == PM_OR && !wp_lo)
      assert (!ev_lo && !ev_hi) else $error("p_or_none_r8");
  end
endmodule

// File: rtl/iaddr_watch.sv
module iaddr_watch
  import iaw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DROP_LSB = 2,
  parameter int NUM_CMP  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [ADDR_W-1:0]                  in_addr,
  input  logic [NUM_CMP*(ADDR_W-DROP_LSB)-1:0] cfg_ref,
  input  logic [2*NUM_CMP-1:0]               cfg_type,
  input  logic [NUM_CMP-1:0]                 cfg_en,
  input  logic [NUM_CMP-1:0]                 cfg_pair_mode,
  input  logic [NUM_CMP-1:0]                 cfg_brk_en,
  output logic [NUM_CMP-1:0]                 wp_hit,
  output logic                               brk_req
);
  localparam int CMP_W    = ADDR_W - DROP_LSB;
  localparam int NUM_PAIR = NUM_CMP / 2;

  logic [CMP_W-1:0]   key;
  logic [NUM_CMP-1:0] eq_v, lt_v, ev_v, wp_d;
  logic [NUM_CMP-1:0] wp_q;
  logic               brk_q;

  assign in_ready = 1'b1; // R1: no back-pressure
  assign key      = in_addr[ADDR_W-1:DROP_LSB]; // R2

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    iaw_comparator #(.W(CMP_W)) u_cmp (
      .key     (key),
      .ref_val (cfg_ref[k*CMP_W +: CMP_W]),
      .is_eq   (eq_v[k]),
      .is_lt   (lt_v[k])
    );
    iaw_event_map u_map (
      .is_eq   (eq_v[k]),
      .is_lt   (lt_v[k]),
      .ctype   (cmp_type_e'(cfg_type[2*k +: 2])),
      .enable  (cfg_en[k] && in_valid),
      .event_o (ev_v[k])
    );
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    iaw_pair_combine u_pair (
      .ev_lo (ev_v[2*p]),
      .ev_hi (ev_v[2*p+1]),
      .mode  (pair_mode_e'(cfg_pair_mode[2*p +: 2])),
      .wp_lo (wp_d[2*p]),
      .wp_hi (wp_d[2*p+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      brk_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      brk_q <= |(wp_d & cfg_brk_en); // R9
    end
  end

  assign wp_hit  = wp_q;
  assign brk_req = brk_q;

  // The low address bits only feed this sanity check (R2: they never reach a compare)
  always_ff @(posedge clk) begin
    if (rst_n && in_valid)
      assert (!$isunknown(in_addr[DROP_LSB-1:0])) else $error("p_low_bits_known_r2");
  end

  p_pulse_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (wp_q == '0 && !brk_q));

  p_brk_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> (|(wp_q & $past(cfg_brk_en))));

  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0) |=> (wp_q == '0));
endmodule

// File: tb/iaddr_watch_tb_top.sv
module iaddr_watch_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [31:0]  in_addr = '0;
  logic [119:0] cfg_ref = '0;
  logic [7:0]   cfg_type = '0;
  logic [3:0]   cfg_en = '0;
  logic [3:0]   cfg_pair_mode = '0;
  logic [3:0]   cfg_brk_en = '0;
  logic [3:0]   wp_hit;
  logic         brk_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  iaddr_watch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .cfg_ref(cfg_ref), .cfg_type(cfg_type), .cfg_en(cfg_en),
    .cfg_pair_mode(cfg_pair_mode), .cfg_brk_en(cfg_brk_en),
    .wp_hit(wp_hit), .brk_req(brk_req)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_cmp(input int k, input logic [31:0] byte_ref, input logic [1:0] t);
    cfg_ref[k*30 +: 30] = byte_ref[31:2];
    cfg_type[2*k +: 2]  = t;
  endtask

  // Present one address, check {brk_req, wp_hit} one cycle later, then check the idle cycle
  task automatic probe(input string req, input logic [31:0] a, input logic [4:0] exp);
    in_valid = 1; in_addr = a;
    @(negedge clk);
    check(req, {brk_req, wp_hit}, exp);
    in_valid = 0;
    @(negedge clk);
    check("R10", {brk_req, wp_hit}, 5'b0);
  endtask

  task automatic t_reset;
    check("R11", {brk_req, wp_hit}, 5'b0);
    rst_n = 1;
    @(negedge clk);
    check("R11", {brk_req, wp_hit}, 5'b0);
    check("R1", {4'b0, in_ready}, 5'b1);
  endtask

  task automatic t_types;
    cfg_en = 4'b0001; cfg_pair_mode = 4'b0000;
    set_cmp(0, 32'h1000, 2'b00);
    probe("R4 eq hit", 32'h1000, 5'b00001);
    probe("R4 eq miss", 32'h1004, 5'b0);
    set_cmp(0, 32'h1000, 2'b01);
    probe("R4 ne", 32'h1004, 5'b00001);
    set_cmp(0, 32'h1000, 2'b10);
    probe("R4 gt hit", 32'h1004, 5'b00001);
    probe("R4 gt equal", 32'h1000, 5'b0);
    set_cmp(0, 32'h1000, 2'b11);
    probe("R4 lt", 32'h0FFC, 5'b00001);
  endtask

  task automatic t_low_bits;
    set_cmp(0, 32'h1000, 2'b00);
    probe("R2", 32'h1003, 5'b00001);
  endtask

  task automatic t_unsigned;
    set_cmp(0, 32'h0000_0010, 2'b11);
    probe("R3 lt", 32'hFFFF_FFF0, 5'b0);
    set_cmp(0, 32'h0000_0010, 2'b10);
    probe("R3 gt", 32'hFFFF_FFF0, 5'b00001);
  endtask

  task automatic t_disable;
    cfg_en = 4'b0000;
    probe("R5", 32'hFFFF_FFF0, 5'b0);
  endtask

  task automatic t_solo;
    cfg_en = 4'b0011; cfg_pair_mode = 4'b0000;
    set_cmp(0, 32'h1000, 2'b00);
    set_cmp(1, 32'h2000, 2'b11);
    probe("R6", 32'h1000, 5'b00011);
    probe("R6", 32'h3000, 5'b0);
  endtask

  task automatic t_in_range;
    cfg_en = 4'b0011; cfg_pair_mode = 4'b0001;
    set_cmp(0, 32'h0FFC, 2'b10);
    set_cmp(1, 32'h2004, 2'b11);
    probe("R7 inside", 32'h1800, 5'b00001);
    probe("R7 low edge", 32'h1000, 5'b00001);
    probe("R7 above", 32'h3000, 5'b0);
  endtask

  task automatic t_out_range;
    cfg_en = 4'b1100; cfg_pair_mode = 4'b1000;
    set_cmp(2, 32'h1000, 2'b11);
    set_cmp(3, 32'h2000, 2'b10);
    probe("R8 below", 32'h0800, 5'b00100);
    probe("R8 inside", 32'h1800, 5'b0);
    cfg_pair_mode = 4'b1100;
    set_cmp(3, 32'h0400, 2'b10);
    probe("R8 mode3", 32'h0800, 5'b01100);
  endtask

  task automatic t_break;
    cfg_brk_en = 4'b0100;
    probe("R9 hit", 32'h0800, 5'b11100);
    cfg_brk_en = 4'b0011;
    probe("R9 masked", 32'h0800, 5'b01100);
    cfg_brk_en = 4'b0000;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_types();
        t_low_bits();
        t_unsigned();
        t_disable();
        t_solo();
        t_in_range();
        t_out_range();
        t_break();
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule